// File: doc/BRIEF.md
# Low-Power Mode Controller with Qualified Wake

This block decides when the processor core and its surroundings may lose their clocks, and when they get them back. Software first writes two 16-bit control registers over a simple register bus. One holds a pending low-power mode and the length of the wake qualification. The other holds one wake enable for each of sixteen wake sources. Writing the mode alone changes nothing. The block moves into that mode only when the core signals that it has executed its idle instruction.

There are three low-power states. In idle, only the core clock is stopped, and the first enabled wake input brings the block straight back. In standby, the core and peripheral clocks are stopped while the oscillator keeps running. An enabled wake condition must then stay active for a programmed number of oscillator cycles, and any gap restarts the count, so short glitches never wake the device. In halt, the oscillator is stopped as well, and only a reset ends the state. Every wake produces a single-cycle pulse. The core clock enable returns in the cycle after that pulse.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, the configuration register (address 0) reads 0x00FC, which is mode 0 with qualification field 63. The enable register (address 1) reads 0x0000. `lp_mode` is 00, all three clock enables are 1, and `wake_pulse` is 0.
- R2: In the configuration register, bits 1:0 hold the mode and bits 7:2 hold the qualification field. Bits 15:8 always read 0 and ignore writes. The enable register stores and returns all 16 bits. Bit 0 is the first external interrupt, 1 the non-maskable interrupt, 2 the watchdog interrupt, 3 to 6 the timer compare trips, 7 to 12 the compare trips, 13 and 14 the two serial receive lines, and 15 the CAN receive line.
- R3: Writing the mode field leaves the state unchanged. In run, an `idle_strobe` sampled at a clock edge moves the block into the selected mode at that edge.
- R4: Mode value 00 selects idle, 01 selects standby, and 10 or 11 select halt. `lp_mode` reports 00 for run and for the wake cycle, 01 for idle, 10 for standby and 11 for halt.
- R5: `core_clk_en` is 1 only in run. `periph_clk_en` is 1 in run, idle and the wake cycle. `osc_en` is 0 only in halt.
- R6: In idle, the first clock edge that samples any enabled wake input active ends the state, with no qualification.
- R7: In standby with qualification field Q, the Q+2-th consecutive clock edge that samples an enabled wake input active ends the state. Any mix of enabled sources counts, as long as at least one of them is active at every edge.
- R8: In standby, an enabled wake condition that drops before the count completes restarts the count. A burst of Q+1 cycles therefore never wakes.
- R9: A wake input whose enable bit is 0 never ends idle or standby.
- R10: A wake raises `wake_pulse` for exactly one cycle. During that cycle `lp_mode` is 00 and `core_clk_en` is still 0. `core_clk_en` is 1 in the following cycle.
- R11: An `idle_strobe` received in idle, standby or halt is ignored.
- R12: Halt is left only by reset. Enabled wake inputs leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rst_n | input | 1 | Active-low asynchronous device reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 configuration, 1 wake enables |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register (combinational) |
| idle_strobe | input | 1 | Core has executed its idle instruction |
| wake_src | input | 16 | Wake source inputs, active high, bit order as in R2 |
| wake_pulse | output | 1 | One-cycle wake indication |
| lp_mode | output | 2 | Current state code as in R4 |
| core_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |

## Verification
The hardest case to reach from the ports is the exact edge of the standby count. The bench must show that Q+1 active cycles never wake while Q+2 do, and that the count carries over when one enabled source hands off to another with no gap. To get there, the bench sets Q to 0, 5 and the reset default 63. At each setting it drives a burst one cycle too short and checks that the block stays in standby. It then drives a full-length run, partly from two overlapping sources. Each full run pushes the expected pulse cycle into the scoreboard, and the monitor compares that cycle with the cycle in which the pulse actually appears.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

   typedef enum logic [2:0] {
      ST_RUN  = 3'd0,
      ST_IDLE = 3'd1,
      ST_STBY = 3'd2,
      ST_HALT = 3'd3,
      ST_WAKE = 3'd4
   } pmc_state_e;

   // reported state codes on lp_mode
   localparam logic [1:0] LPM_RUN  = 2'b00;
   localparam logic [1:0] LPM_IDLE = 2'b01;
   localparam logic [1:0] LPM_STBY = 2'b10;
   localparam logic [1:0] LPM_HALT = 2'b11;

   // programmed mode values in the configuration register
   localparam logic [1:0] SEL_IDLE = 2'b00;
   localparam logic [1:0] SEL_STBY = 2'b01;

   localparam logic ADDR_CFG = 1'b0;
   localparam logic ADDR_WEN = 1'b1;

endpackage

// File: rtl/pmc_regs.sv
module pmc_regs #(
   parameter int DATA_W  = 16,
   parameter int NUM_SRC = 16,
   parameter int MODE_W  = 2,
   parameter int QUAL_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [MODE_W-1:0] mode_sel,
   output logic [QUAL_W-1:0] qual_len,
   output logic [NUM_SRC-1:0] wake_en
);
   import pmc_pkg::*;

   localparam int CFG_USED = MODE_W + QUAL_W;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_sel <= '0;
         qual_len <= '1;
         wake_en  <= '0;
      end else if (bus_wr) begin
         if (bus_addr == ADDR_CFG) begin
            mode_sel <= bus_wdata[MODE_W-1:0];
            qual_len <= bus_wdata[MODE_W +: QUAL_W];
         end else begin
            wake_en <= bus_wdata[NUM_SRC-1:0];
         end
      end
   end

   logic [DATA_W-1:0] cfg_view, wen_view;

   generate
      if (CFG_USED < DATA_W) begin : g_cfg_pad
         assign cfg_view = {{(DATA_W-CFG_USED){1'b0}}, qual_len, mode_sel};
      end else begin : g_cfg_full
         assign cfg_view = {qual_len, mode_sel};
      end
      if (NUM_SRC < DATA_W) begin : g_wen_pad
         assign wen_view = {{(DATA_W-NUM_SRC){1'b0}}, wake_en};
      end else begin : g_wen_full
         assign wen_view = wake_en;
      end
   endgenerate

   assign bus_rdata = (bus_addr == ADDR_CFG) ? cfg_view : wen_view;

endmodule

// File: rtl/pmc_sync.sv
module pmc_sync #(
   parameter int NUM_SRC = 16,
   parameter int STAGES  = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_in,
   output logic [NUM_SRC-1:0] src_out
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign src_out = src_in;
      end else begin : g_chain
         logic [NUM_SRC-1:0] pipe [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
            end else begin
               pipe[0] <= src_in;
               for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            end
         end
         assign src_out = pipe[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/pmc_qual.sv
module pmc_qual #(
   parameter int QUAL_W = 6,
   parameter int BIAS   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm,
   input  logic              hit,
   input  logic [QUAL_W-1:0] qual_len,
   output logic              done
);
   localparam int MAX_LEN = (1 << QUAL_W) - 1 + BIAS;
   localparam int CNT_W   = $clog2(MAX_LEN + 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] target;

   assign target = CNT_W'(qual_len) + CNT_W'(BIAS - 1);
   assign done   = arm && hit && (cnt_q == target);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (!arm || !hit) cnt_q <= '0;
      else if (!done)        cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm #(
   parameter int MODE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              idle_strobe,
   input  logic [MODE_W-1:0] mode_sel,
   input  logic              any_hit,
   input  logic              qual_done,
   output logic              stby_arm,
   output logic              wake_pulse,
   output logic [1:0]        lp_mode,
   output logic              core_clk_en,
   output logic              periph_clk_en,
   output logic              osc_en
);
   import pmc_pkg::*;

   pmc_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_RUN: if (idle_strobe) begin
            if (mode_sel[1:0] == SEL_IDLE)      st_d = ST_IDLE;
            else if (mode_sel[1:0] == SEL_STBY) st_d = ST_STBY;
            else                                st_d = ST_HALT;
         end
         ST_IDLE: if (any_hit)   st_d = ST_WAKE;
         ST_STBY: if (qual_done) st_d = ST_WAKE;
         ST_HALT: st_d = ST_HALT;
         ST_WAKE: st_d = ST_RUN;
         default: st_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_RUN;
      else        st_q <= st_d;
   end

   always_comb begin
      case (st_q)
         ST_IDLE: lp_mode = LPM_IDLE;
         ST_STBY: lp_mode = LPM_STBY;
         ST_HALT: lp_mode = LPM_HALT;
         default: lp_mode = LPM_RUN;
      endcase
   end

   assign stby_arm      = (st_q == ST_STBY);
   assign wake_pulse    = (st_q == ST_WAKE);
   assign core_clk_en   = (st_q == ST_RUN);
   assign periph_clk_en = (st_q == ST_RUN) || (st_q == ST_WAKE) || (st_q == ST_IDLE);
   assign osc_en        = (st_q != ST_HALT);

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
   parameter int DATA_W      = 16,
   parameter int NUM_SRC     = 16,
   parameter int MODE_W      = 2,
   parameter int QUAL_W      = 6,
   parameter int QUAL_BIAS   = 2,
   parameter int SYNC_STAGES = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic               bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic               idle_strobe,
   input  logic [NUM_SRC-1:0] wake_src,
   output logic               wake_pulse,
   output logic [1:0]         lp_mode,
   output logic               core_clk_en,
   output logic               periph_clk_en,
   output logic               osc_en
);
   generate
      if (NUM_SRC > DATA_W)          begin : g_bad_src  $error("NUM_SRC exceeds DATA_W");  end
      if (MODE_W + QUAL_W > DATA_W)  begin : g_bad_cfg  $error("config fields exceed DATA_W"); end
      if (MODE_W != 2)               begin : g_bad_mode $error("MODE_W must be 2");        end
      if (QUAL_BIAS < 1)             begin : g_bad_bias $error("QUAL_BIAS must be >= 1");  end
      if (SYNC_STAGES < 0)           begin : g_bad_sync $error("SYNC_STAGES negative");    end
   endgenerate

   logic [MODE_W-1:0]  mode_sel;
   logic [QUAL_W-1:0]  qual_len;
   logic [NUM_SRC-1:0] wake_en;
   logic [NUM_SRC-1:0] src_s;
   logic               any_hit;
   logic               stby_arm;
   logic               qual_done;

   pmc_regs #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC), .MODE_W(MODE_W), .QUAL_W(QUAL_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .mode_sel(mode_sel), .qual_len(qual_len), .wake_en(wake_en)
   );

   pmc_sync #(.NUM_SRC(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .src_in(wake_src), .src_out(src_s)
   );

   assign any_hit = |(src_s & wake_en);

   pmc_qual #(.QUAL_W(QUAL_W), .BIAS(QUAL_BIAS)) u_qual (
      .clk(clk), .rst_n(rst_n), .arm(stby_arm), .hit(any_hit),
      .qual_len(qual_len), .done(qual_done)
   );

   pmc_fsm #(.MODE_W(MODE_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .idle_strobe(idle_strobe), .mode_sel(mode_sel),
      .any_hit(any_hit), .qual_done(qual_done), .stby_arm(stby_arm),
      .wake_pulse(wake_pulse), .lp_mode(lp_mode), .core_clk_en(core_clk_en),
      .periph_clk_en(periph_clk_en), .osc_en(osc_en)
   );

endmodule

// File: rtl/pmc_chk.sv
module pmc_chk #(
   parameter int DATA_W = 16,
   parameter int MODE_W = 2,
   parameter int QUAL_W = 6,
   parameter int QUAL_BIAS = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_addr,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              idle_strobe,
   input logic              hit,
   input logic [QUAL_W-1:0] qual_len,
   input logic              wake_pulse,
   input logic [1:0]        lp_mode,
   input logic              core_clk_en
);
   localparam int RUN_W = QUAL_W + 2;

   // consecutive standby cycles with an enabled wake condition, before this one
   logic [RUN_W-1:0] run_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         run_cnt <= '0;
      else if (lp_mode == 2'b10 && hit) begin
         if (run_cnt != '1) run_cnt <= run_cnt + 1'b1;
      end else                            run_cnt <= '0;
   end

   p_pulse_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |=> !wake_pulse);

   p_clk_after_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |=> core_clk_en);

   p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == 1'b0) |-> (bus_rdata[DATA_W-1:MODE_W+QUAL_W] == '0));

   p_halt_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (lp_mode == 2'b11) |=> (lp_mode == 2'b11));

   p_entry_on_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(core_clk_en) |-> ($past(idle_strobe) && !wake_pulse));

   p_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((lp_mode == 2'b01 || lp_mode == 2'b10) && !hit) |=> !wake_pulse);

   p_qual_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (lp_mode == 2'b10 && !(hit && (run_cnt >= RUN_W'(qual_len) + RUN_W'(QUAL_BIAS - 1))))
      |=> !wake_pulse);

endmodule

bind pwr_mode_ctrl pmc_chk #(.DATA_W(DATA_W), .MODE_W(MODE_W), .QUAL_W(QUAL_W), .QUAL_BIAS(QUAL_BIAS)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
   .idle_strobe(idle_strobe), .hit(any_hit), .qual_len(qual_len),
   .wake_pulse(wake_pulse), .lp_mode(lp_mode), .core_clk_en(core_clk_en)
);

// File: tb/test_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module test_pwr_mode_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_addr = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        idle_strobe = 1'b0;
   logic [15:0] wake_src = '0;
   logic        wake_pulse;
   logic [1:0]  lp_mode;
   logic        core_clk_en, periph_clk_en, osc_en;

   always #10 clk = ~clk;   // 50 MHz

   pwr_mode_ctrl i_pwr_mode_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .idle_strobe(idle_strobe),
      .wake_src(wake_src), .wake_pulse(wake_pulse), .lp_mode(lp_mode),
      .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en), .osc_en(osc_en)
   );

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   int exp_q[$];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic finish_up();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   endtask

   // scoreboard monitor: each wake pulse must match the next expected cycle
   always @(negedge clk) begin
      if (rst_n && wake_pulse) begin
         if (exp_q.size() == 0) chk("R10 unexpected wake pulse at cycle", cyc, 32'hFFFF_FFFF);
         else chk("R7 wake pulse cycle", cyc, exp_q.pop_front());
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic a, input logic [15:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input string tag, input logic a, input logic [15:0] exp);
      bus_addr = a;
      #1;
      chk(tag, bus_rdata, exp);
   endtask

   task automatic strobe();
      idle_strobe = 1'b1;
      @(negedge clk);
      idle_strobe = 1'b0;
   endtask

   task automatic expect_wake(input int n);
      exp_q.push_back(cyc + n);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R1 reset state
      rd("R1 cfg reset", 1'b0, 16'h00FC);
      rd("R1 wen reset", 1'b1, 16'h0000);
      chk("R1 lp_mode reset", lp_mode, 2'b00);
      chk("R1 clocks reset", {core_clk_en, periph_clk_en, osc_en, wake_pulse}, 4'b1110);

      // R2 field layout and reserved bits
      wr(1'b0, 16'hFFFF);
      rd("R2 reserved bits", 1'b0, 16'h00FF);
      wr(1'b1, 16'hA5C3);
      rd("R2 enable readback", 1'b1, 16'hA5C3);

      // R3 mode write alone has no effect
      wr(1'b0, 16'h0001);
      tick(3);
      chk("R3 no entry without strobe", {lp_mode, core_clk_en}, 3'b001);

      // standby, Q=0 -> 2 cycles, enable serial line bit 13
      wr(1'b1, 16'h2000);
      strobe();
      chk("R4 standby code", lp_mode, 2'b10);
      chk("R5 standby clocks", {core_clk_en, periph_clk_en, osc_en}, 3'b001);
      wake_src = 16'h0020;
      tick(10);
      chk("R9 disabled source in standby", lp_mode, 2'b10);
      wake_src = 16'h0000;
      strobe();
      tick(2);
      chk("R11 strobe ignored in standby", lp_mode, 2'b10);
      wake_src = 16'h2000;
      tick(1);
      wake_src = 16'h0000;
      tick(5);
      chk("R8 short burst Q=0", lp_mode, 2'b10);
      expect_wake(2);
      wake_src = 16'h2000;
      tick(2);
      chk("R10 pulse cycle", {wake_pulse, lp_mode, core_clk_en}, 4'b1000);
      tick(1);
      chk("R10 clock back", {wake_pulse, core_clk_en}, 2'b01);
      wake_src = 16'h0000;

      // standby, Q=5 -> 7 cycles, two enabled sources with hand-off
      wr(1'b0, 16'h0015);
      wr(1'b1, 16'h2008);
      strobe();
      wake_src = 16'h2000;
      tick(6);
      wake_src = 16'h0000;
      tick(3);
      chk("R8 burst of Q+1 Q=5", lp_mode, 2'b10);
      expect_wake(7);
      wake_src = 16'h0008;
      tick(4);
      wake_src = 16'h2000;
      tick(3);
      chk("R7 hand-off wake Q=5", wake_pulse, 1'b1);
      tick(1);
      wake_src = 16'h0000;

      // idle mode
      wr(1'b0, 16'h0000);
      wr(1'b1, 16'h0001);
      strobe();
      chk("R4 idle code", lp_mode, 2'b01);
      chk("R5 idle clocks", {core_clk_en, periph_clk_en, osc_en}, 3'b011);
      wake_src = 16'h0002;
      tick(4);
      chk("R9 disabled source in idle", lp_mode, 2'b01);
      expect_wake(1);
      wake_src = 16'h0001;
      tick(1);
      chk("R6 idle immediate wake", wake_pulse, 1'b1);
      tick(1);
      wake_src = 16'h0000;

      // halt via mode 11
      wr(1'b0, 16'h0003);
      strobe();
      chk("R4 halt code", lp_mode, 2'b11);
      chk("R5 halt clocks", {core_clk_en, periph_clk_en, osc_en}, 3'b000);
      wake_src = 16'h0001;
      strobe();
      tick(50);
      chk("R12 halt holds", lp_mode, 2'b11);
      rst_n = 1'b0;
      wake_src = 16'h0000;
      tick(2);
      rst_n = 1'b1;
      tick(1);
      chk("R12 reset leaves halt", {lp_mode, core_clk_en}, 3'b001);
      rd("R1 cfg after reset", 1'b0, 16'h00FC);
      rd("R1 wen after reset", 1'b1, 16'h0000);

      // default Q=63 -> 65 cycles, CAN receive bit 15
      wr(1'b0, 16'h00FD);
      wr(1'b1, 16'h8000);
      strobe();
      wake_src = 16'h8000;
      tick(64);
      wake_src = 16'h0000;
      tick(2);
      chk("R8 burst of 64 at Q=63", lp_mode, 2'b10);
      expect_wake(65);
      wake_src = 16'h8000;
      tick(65);
      chk("R7 wake after 65", wake_pulse, 1'b1);
      tick(1);
      wake_src = 16'h0000;
      tick(3);
      chk("R10 all expected pulses seen", exp_q.size(), 0);
      finish_up();
   end

endmodule